// File: doc/BRIEF.md
# Integer ALU Slice with Condition Evaluation

This block is the arithmetic and logic slice of an execution datapath. Operands, an operation code, a condition selector and a multiply-step direction bit arrive each cycle. In the same cycle the block returns a result word, the raw adder carry, the carry value it will store next, a signed-overflow flag and one condition bit. A single stored carry flag is held in a register. Each operation variant decides whether that flag feeds the adder, and whether the flag is cleared, loaded from the adder or left alone.

The stored carry is visible at an output. A sequencer uses it to chain multi-word arithmetic with the unsigned variants. The signed and long variants leave it clean. The no-carry and logic variants leave it untouched. The condition output serves branch and trap decisions: sign and zero tests, overflow, an array-bounds test and a check that a value fits in a signed range one bit narrower than the word. Each test also has a complement code.

Top module: `alu_cond_unit`

## Requirements
- R1: Add variants produce left + right + cin. Subtract variants produce left + NOT(right) + NOT(cin), so cin=1 means an extra borrow. The raw carry is bit WIDTH of that sum. Op codes: 0 signed add, 1 signed sub, 2 unsigned add, 3 unsigned sub, 4 no-carry add, 5 no-carry sub, 6 long add, 7 long sub.
- R2: Op 8 is AND, 10 is XOR and 9 is OR. The field ops 14 and 15 also produce the OR of the operands. All five force the raw carry to 0.
- R3: cin equals the stored carry for ops 0–3, 14 and 15. cin is 0 for every other legal op.
- R4: The next stored carry is 0 for ops 0, 1, 6, 7, 12 and 13. It equals the raw carry for ops 2 and 3. It keeps the stored value for ops 4, 5, 8–11, 14 and 15.
- R5: The stored carry takes the next-carry value on each rising clock edge while hold_i is low. It stays unchanged while hold_i is high. It is 0 while rst_ni is low.
- R6: Overflow is 1 when left and the effective right operand have equal sign bits and the result sign differs from them. The effective right operand is the two's-complement negation of right for ops 1, 3, 5, 7 and 11, and is right itself for every other op.
- R7: The condition selector bits [2:0] pick the base test: 0 result zero, 1 result negative, 2 zero or negative, 3 overflow, 4 bounds pass, 5 range fail, 6 constant false.
- R8: Setting selector bit 3 inverts the chosen base test. This gives not-zero, non-negative, greater-than-zero, no-overflow, bounds fail, range ok and constant true.
- R9: Bounds pass is NOT(left MSB clear AND result MSB set). Range fail is 1 when bits WIDTH-1 and WIDTH-2 differ in left, in right or in the result.
- R10: Op codes 16–31 drive result, raw carry and overflow to 0, keep the stored carry and raise illegal_o. Selector values 7 and 15 force cond_o to 0 and raise illegal_o.
- R11: Op 11 (bounds check) and op 13 (divide step) run the adder as a subtract. Op 12 (multiply step) subtracts when mul_sub_i is 1 and adds when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the carry flag |
| hold_i | input | 1 | Freezes the stored carry when high |
| op_i | input | 5 | Operation code |
| cond_sel_i | input | 4 | Condition selector; bit 3 inverts |
| mul_sub_i | input | 1 | Direction of the multiply step |
| left_i | input | WIDTH | Left operand |
| right_i | input | WIDTH | Right operand |
| result_o | output | WIDTH | Result word |
| carry_raw_o | output | 1 | Adder carry-out of this operation |
| carry_next_o | output | 1 | Value the carry flag loads at the next edge |
| carry_q_o | output | 1 | Current stored carry |
| ovf_o | output | 1 | Signed overflow |
| cond_o | output | 1 | Selected condition |
| illegal_o | output | 1 | Unused op or selector code |

## Verification
The checker watches the carry-flag bookkeeping every cycle. It confirms that logic and field ops never raise a raw carry and that each op class clears, loads or keeps the flag as required. It also confirms that hold freezes the flag and that the zero test and the illegal encodings behave correctly. Arithmetic values depend on exact operands, so only the bench scenarios can show them. These cover carry and borrow injection from a stored 1, overflow at the signed extremes, bounds and range tests near the sign boundary, and the add/subtract choice of the step ops.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD_S  = 5'd0,
    OP_SUB_S  = 5'd1,
    OP_ADD_U  = 5'd2,
    OP_SUB_U  = 5'd3,
    OP_ADD_NC = 5'd4,
    OP_SUB_NC = 5'd5,
    OP_ADD_L  = 5'd6,
    OP_SUB_L  = 5'd7,
    OP_AND    = 5'd8,
    OP_OR     = 5'd9,
    OP_XOR    = 5'd10,
    OP_BOUND  = 5'd11,
    OP_MSTEP  = 5'd12,
    OP_DSTEP  = 5'd13,
    OP_FLD    = 5'd14,
    OP_FLDK   = 5'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    CT_ZERO  = 3'd0,
    CT_NEG   = 3'd1,
    CT_LE    = 3'd2,
    CT_OVF   = 3'd3,
    CT_BND   = 3'd4,
    CT_RNG   = 3'd5,
    CT_FALSE = 3'd6,
    CT_BAD   = 3'd7
  } cond_base_e;

  localparam int unsigned NUM_BASE = 8;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_AND  = 3'd1,
    FN_OR   = 3'd2,
    FN_XOR  = 3'd3,
    FN_NONE = 3'd4
  } alu_fn_e;

  typedef enum logic [1:0] {
    CO_CLEAR = 2'd0,
    CO_RAW   = 2'd1,
    CO_KEEP  = 2'd2
  } cout_sel_e;

  typedef struct packed {
    alu_fn_e   fn;
    logic      sub;
    logic      cin_store;
    cout_sel_e cout;
    logic      neg_ovf;
    logic      bad;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [4:0] op_i,
  input  logic       mul_sub_i,
  output alu_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{fn: FN_ADD, sub: 1'b0, cin_store: 1'b0, cout: CO_KEEP,
               neg_ovf: 1'b0, bad: 1'b0};
    case (op_i)
      OP_ADD_S:  begin ctrl_o.cin_store = 1'b1; ctrl_o.cout = CO_CLEAR; end
      OP_SUB_S:  begin ctrl_o.sub = 1'b1; ctrl_o.cin_store = 1'b1;
                       ctrl_o.cout = CO_CLEAR; ctrl_o.neg_ovf = 1'b1; end
      OP_ADD_U:  begin ctrl_o.cin_store = 1'b1; ctrl_o.cout = CO_RAW; end
      OP_SUB_U:  begin ctrl_o.sub = 1'b1; ctrl_o.cin_store = 1'b1;
                       ctrl_o.cout = CO_RAW; ctrl_o.neg_ovf = 1'b1; end
      OP_ADD_NC: ctrl_o.cout = CO_KEEP;
      OP_SUB_NC: begin ctrl_o.sub = 1'b1; ctrl_o.neg_ovf = 1'b1; end
      OP_ADD_L:  ctrl_o.cout = CO_CLEAR;
      OP_SUB_L:  begin ctrl_o.sub = 1'b1; ctrl_o.cout = CO_CLEAR;
                       ctrl_o.neg_ovf = 1'b1; end
      OP_AND:    ctrl_o.fn = FN_AND;
      OP_OR:     ctrl_o.fn = FN_OR;
      OP_XOR:    ctrl_o.fn = FN_XOR;
      OP_BOUND:  begin ctrl_o.sub = 1'b1; ctrl_o.neg_ovf = 1'b1; end
      OP_MSTEP:  begin ctrl_o.sub = mul_sub_i; ctrl_o.cout = CO_CLEAR; end
      OP_DSTEP:  begin ctrl_o.sub = 1'b1; ctrl_o.cout = CO_CLEAR; end
      OP_FLD, OP_FLDK: begin ctrl_o.fn = FN_OR; ctrl_o.cin_store = 1'b1; end
      default:   begin ctrl_o.fn = FN_NONE; ctrl_o.bad = 1'b1; end
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_ctrl_t         ctrl_i,
  input  logic [WIDTH-1:0]  left_i,
  input  logic [WIDTH-1:0]  right_i,
  input  logic              carry_q_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_raw_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] right_eff;
  logic             cin_eff, cin_add;
  logic [WIDTH:0]   sum;
  logic             right_sgn, neg_msb;

  assign right_eff = ctrl_i.sub ? ~right_i : right_i;
  assign cin_eff   = ctrl_i.cin_store & carry_q_i;
  // borrow semantics: a set carry on subtract removes the +1
  assign cin_add   = ctrl_i.sub ? ~cin_eff : cin_eff;
  assign sum       = {1'b0, left_i} + {1'b0, right_eff} + {{WIDTH{1'b0}}, cin_add};

  // sign of two's-complement negation without forming the full word
  assign neg_msb   = (right_i != '0) & (~right_i[MSB] | (right_i[MSB-1:0] == '0));
  assign right_sgn = ctrl_i.neg_ovf ? neg_msb : right_i[MSB];

  always_comb begin
    result_o    = '0;
    carry_raw_o = 1'b0;
    case (ctrl_i.fn)
      FN_ADD: begin result_o = sum[MSB:0]; carry_raw_o = sum[WIDTH]; end
      FN_AND: result_o = left_i & right_i;
      FN_OR:  result_o = left_i | right_i;
      FN_XOR: result_o = left_i ^ right_i;
      default: result_o = '0;
    endcase
  end

  assign ovf_o = ~ctrl_i.bad & (left_i[MSB] == right_sgn) & (left_i[MSB] != result_o[MSB]);
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]        cond_sel_i,
  input  logic [1:0]        left_top_i,
  input  logic [1:0]        right_top_i,
  input  logic [WIDTH-1:0]  result_i,
  input  logic              ovf_i,
  output logic              cond_o,
  output logic              bad_o
);
  logic [NUM_BASE-1:0] base;
  logic is_zero, is_neg, rng_fail;

  assign is_zero  = (result_i == '0);
  assign is_neg   = result_i[WIDTH-1];
  assign rng_fail = (left_top_i[1] ^ left_top_i[0]) | (right_top_i[1] ^ right_top_i[0])
                  | (result_i[WIDTH-1] ^ result_i[WIDTH-2]);

  always_comb begin
    base           = '0;
    base[CT_ZERO]  = is_zero;
    base[CT_NEG]   = is_neg;
    base[CT_LE]    = is_zero | is_neg;
    base[CT_OVF]   = ovf_i;
    base[CT_BND]   = ~(~left_top_i[1] & is_neg);
    base[CT_RNG]   = rng_fail;
    base[CT_FALSE] = 1'b0;
    base[CT_BAD]   = 1'b0;
  end

  assign bad_o  = (cond_sel_i[2:0] == CT_BAD);
  assign cond_o = bad_o ? 1'b0 : (base[cond_sel_i[2:0]] ^ cond_sel_i[3]);
endmodule

// File: rtl/alu_carry_flag.sv
module alu_carry_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [4:0]       op_i,
  input  logic [3:0]       cond_sel_i,
  input  logic             mul_sub_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_raw_o,
  output logic             carry_next_o,
  output logic             carry_q_o,
  output logic             ovf_o,
  output logic             cond_o,
  output logic             illegal_o
);
  alu_ctrl_t ctrl;
  logic      cond_bad;

  alu_decode i_decode (
    .op_i      (op_i),
    .mul_sub_i (mul_sub_i),
    .ctrl_o    (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) i_datapath (
    .ctrl_i      (ctrl),
    .left_i      (left_i),
    .right_i     (right_i),
    .carry_q_i   (carry_q_o),
    .result_o    (result_o),
    .carry_raw_o (carry_raw_o),
    .ovf_o       (ovf_o)
  );

  alu_cond_eval #(.WIDTH(WIDTH)) i_cond (
    .cond_sel_i  (cond_sel_i),
    .left_top_i  (left_i[WIDTH-1 -: 2]),
    .right_top_i (right_i[WIDTH-1 -: 2]),
    .result_i    (result_o),
    .ovf_i       (ovf_o),
    .cond_o      (cond_o),
    .bad_o       (cond_bad)
  );

  always_comb begin
    case (ctrl.cout)
      CO_CLEAR: carry_next_o = 1'b0;
      CO_RAW:   carry_next_o = carry_raw_o;
      default:  carry_next_o = carry_q_o;
    endcase
  end

  alu_carry_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .d_i    (carry_next_o),
    .q_o    (carry_q_o)
  );

  assign illegal_o = ctrl.bad | cond_bad;
endmodule

// File: rtl/alu_cond_unit_chk.sv
module alu_cond_unit_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_i,
  input logic [4:0]       op_i,
  input logic [3:0]       cond_sel_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_raw_o,
  input logic             carry_next_o,
  input logic             carry_q_o,
  input logic             ovf_o,
  input logic             cond_o,
  input logic             illegal_o
);
  logic logic_op, clear_op, raw_op, keep_op, op_bad;
  assign logic_op = (op_i inside {5'd8, 5'd9, 5'd10, 5'd14, 5'd15});
  assign clear_op = (op_i inside {5'd0, 5'd1, 5'd6, 5'd7, 5'd12, 5'd13});
  assign raw_op   = (op_i inside {5'd2, 5'd3});
  assign keep_op  = (op_i inside {5'd4, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11, 5'd14, 5'd15});
  assign op_bad   = (op_i >= 5'd16);

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_op |-> !carry_raw_o); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(carry_q_o)); // R5
  AST_CARRY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> carry_q_o == $past(carry_next_o)); // R5
  AST_CLEAR_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_op |-> !carry_next_o); // R4
  AST_RAW_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_op |-> carry_next_o == carry_raw_o); // R4
  AST_KEEP_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_op || op_bad) |-> carry_next_o == carry_q_o); // R4
  AST_ILLEGAL_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_bad |-> (illegal_o && result_o == '0 && !carry_raw_o && !ovf_o)); // R10
  AST_ILLEGAL_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i[2:0] == 3'd7) |-> (illegal_o && !cond_o)); // R10
  AST_ZERO_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd0) |-> cond_o == (result_o == '0)); // R7
  AST_FALSE_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i[2:0] == 3'd6) |-> cond_o == cond_sel_i[3]); // R8
endmodule

bind alu_cond_unit alu_cond_unit_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_alu_cond_unit.sv
`timescale 1ns/1ps
module test_alu_cond_unit;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hold_i = 1'b0;
  logic [4:0]    op_i = '0;
  logic [3:0]    cond_sel_i = '0;
  logic          mul_sub_i = 1'b0;
  logic [W-1:0]  left_i = '0, right_i = '0;
  logic [W-1:0]  result_o;
  logic          carry_raw_o, carry_next_o, carry_q_o, ovf_o, cond_o, illegal_o;

  int n_chk = 0, n_bad = 0;
  logic mdl_c = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic craw, cnext, cq, ovf, cond, ill;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  alu_cond_unit #(.WIDTH(W)) i_alu_cond_unit (.*, .clk_i(clk));

  function automatic exp_t model(logic [4:0] op, logic [3:0] cs, logic ms,
                                 logic [W-1:0] l, logic [W-1:0] r, logic cq);
    exp_t e;
    logic sub, addop, cin, b;
    logic [W:0] s;
    logic [W-1:0] rn;
    sub   = (op inside {1, 3, 5, 7, 11, 13}) || (op == 12 && ms);
    addop = (op <= 7) || (op inside {11, 12, 13});
    cin   = (op inside {0, 1, 2, 3, 14, 15}) ? cq : 1'b0;
    if (sub) s = {1'b0, l} + {1'b0, ~r} + (W+1)'(!cin);
    else     s = {1'b0, l} + {1'b0, r} + (W+1)'(cin);
    e.res  = addop ? s[W-1:0] : (op == 8) ? (l & r) : (op == 10) ? (l ^ r) : (l | r);
    e.craw = addop ? s[W] : 1'b0;
    e.cnext = (op inside {0, 1, 6, 7, 12, 13}) ? 1'b0 : (op inside {2, 3}) ? e.craw : cq;
    rn = (op inside {1, 3, 5, 7, 11}) ? (~r + 1) : r;
    e.ovf = (l[W-1] == rn[W-1]) && (l[W-1] != e.res[W-1]);
    if (op > 15) begin e.res = '0; e.craw = 0; e.ovf = 0; e.cnext = cq; end
    case (cs[2:0])
      3'd0: b = (e.res == 0);
      3'd1: b = e.res[W-1];
      3'd2: b = (e.res == 0) || e.res[W-1];
      3'd3: b = e.ovf;
      3'd4: b = !(!l[W-1] && e.res[W-1]);
      3'd5: b = (l[W-1] != l[W-2]) || (r[W-1] != r[W-2]) || (e.res[W-1] != e.res[W-2]);
      default: b = 1'b0;
    endcase
    e.cond = (cs[2:0] == 3'd7) ? 1'b0 : (b ^ cs[3]);
    e.ill  = (op > 15) || (cs[2:0] == 3'd7);
    e.cq   = cq;
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [3:0] cs, input logic ms,
                       input logic [W-1:0] l, input logic [W-1:0] r,
                       input logic hold, input string tag);
    exp_t e;
    @(negedge clk);
    op_i = op; cond_sel_i = cs; mul_sub_i = ms; left_i = l; right_i = r; hold_i = hold;
    e = model(op, cs, ms, l, r, mdl_c);
    e.tag = tag;
    sb.push_back(e);
    if (!hold) mdl_c = e.cnext;
  endtask

  task automatic fail_line(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // monitor: sample half a cycle after the driver, before the next edge
  initial forever begin
    @(negedge clk);
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      bit bad;
      e = sb.pop_front();
      bad = 0;
      n_chk++;
      if (result_o !== e.res)       begin bad = 1; fail_line(e.tag, "result", result_o, e.res); end
      if (carry_raw_o !== e.craw)   begin bad = 1; fail_line(e.tag, "carry_raw", W'(carry_raw_o), W'(e.craw)); end
      if (carry_next_o !== e.cnext) begin bad = 1; fail_line(e.tag, "carry_next", W'(carry_next_o), W'(e.cnext)); end
      if (carry_q_o !== e.cq)       begin bad = 1; fail_line(e.tag, "carry_q", W'(carry_q_o), W'(e.cq)); end
      if (ovf_o !== e.ovf)          begin bad = 1; fail_line(e.tag, "ovf", W'(ovf_o), W'(e.ovf)); end
      if (cond_o !== e.cond)        begin bad = 1; fail_line(e.tag, "cond", W'(cond_o), W'(e.cond)); end
      if (illegal_o !== e.ill)      begin bad = 1; fail_line(e.tag, "illegal", W'(illegal_o), W'(e.ill)); end
      if (bad) n_bad++;
    end
  end

  task automatic check_reset(string tag);
    n_chk++;
    if (carry_q_o !== 1'b0) begin n_bad++; fail_line(tag, "carry_q in reset", W'(carry_q_o), '0); end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL all watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #12;
    check_reset("R5");
    @(negedge clk); rst_ni = 1'b1;
    // R1 basic add, R4 unsigned load
    drive(0, 0, 0, 32'd5, 32'd7, 0, "R1");
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, "R4");
    drive(0, 0, 0, 32'd5, 32'd7, 0, "R3");           // stored carry 1 injected
    drive(5, 0, 0, 32'd10, 32'd3, 0, "R1");          // plain subtract
    // R5 hold freezes the flag
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 1, "R5");
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, "R5");
    drive(1, 0, 0, 32'd10, 32'd3, 0, "R1");          // borrow from stored carry
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, "R4");
    drive(4, 0, 0, 32'd5, 32'd7, 0, "R3");           // cin forced 0, keep flag
    drive(8, 0, 0, 32'hF0F0_1234, 32'hFF00_FF00, 0, "R2");
    drive(9, 0, 0, 32'hF0F0_1234, 32'hFF00_FF00, 0, "R2");
    drive(10, 0, 0, 32'hF0F0_1234, 32'hFF00_FF00, 0, "R2");
    drive(14, 0, 0, 32'h0000_00F0, 32'h0000_0F00, 0, "R2");
    drive(3, 0, 0, 32'd3, 32'd3, 0, "R4");           // unsigned sub with borrow
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, "R4");
    drive(6, 0, 0, 32'd1, 32'd1, 0, "R4");           // long add clears
    // R6 overflow
    drive(0, 3, 0, 32'h7FFF_FFFF, 32'd1, 0, "R6");
    drive(1, 3, 0, 32'h8000_0000, 32'd1, 0, "R6");
    drive(7, 11, 0, 32'd0, 32'h8000_0000, 0, "R6");
    drive(5, 3, 0, 32'h8000_0000, 32'd5, 0, "R6");
    // R7 / R8 conditions
    drive(5, 0, 0, 32'd5, 32'd5, 0, "R7");
    drive(5, 8, 0, 32'd5, 32'd5, 0, "R8");
    drive(5, 2, 0, 32'd3, 32'd9, 0, "R7");
    drive(5, 10, 0, 32'd9, 32'd3, 0, "R8");
    drive(5, 9, 0, 32'd3, 32'd9, 0, "R8");
    drive(5, 1, 0, 32'd3, 32'd9, 0, "R7");
    drive(4, 6, 0, 32'd1, 32'd1, 0, "R7");
    drive(4, 14, 0, 32'd1, 32'd1, 0, "R8");
    // R9 bounds and range
    drive(11, 4, 0, 32'd3, 32'd10, 0, "R9");
    drive(11, 12, 0, 32'd3, 32'd10, 0, "R9");
    drive(11, 4, 0, 32'hFFFF_FFFF, 32'd10, 0, "R9");
    drive(11, 4, 0, 32'd12, 32'd10, 0, "R9");
    drive(4, 5, 0, 32'h4000_0000, 32'd0, 0, "R9");
    drive(4, 13, 0, 32'h0000_0100, 32'd1, 0, "R9");
    drive(4, 5, 0, 32'd0, 32'hBFFF_FFFF, 0, "R9");
    // R11 step ops
    drive(12, 0, 0, 32'd20, 32'd6, 0, "R11");
    drive(12, 0, 1, 32'd20, 32'd6, 0, "R11");
    drive(13, 0, 0, 32'd20, 32'd6, 0, "R11");
    // R10 illegal encodings, with a set flag
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, "R10");
    drive(20, 0, 0, 32'h1234_5678, 32'h1111_1111, 0, "R10");
    drive(31, 8, 0, 32'h1234_5678, 32'h1111_1111, 0, "R10");
    drive(0, 7, 0, 32'd1, 32'd2, 0, "R10");
    drive(0, 15, 0, 32'd0, 32'd0, 0, "R10");
    // R5 reset clears a set flag
    drive(2, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, "R5");
    drive(4, 0, 0, 32'd0, 32'd0, 0, "R5");
    @(negedge clk); #3;
    @(negedge clk); rst_ni = 1'b0; mdl_c = 1'b0;
    #1 check_reset("R5");
    @(negedge clk); rst_ni = 1'b1;
    drive(4, 0, 0, 32'd0, 32'd0, 0, "R5");
    @(negedge clk); #3;
    finish_run();
  end
endmodule